// File: doc/BRIEF.md
# Paired Byte FIFO with Threshold Interrupts

This block holds two 64-entry byte queues. The transmit queue is filled by a host and drained by a modem. The receive queue is filled by the modem and drained by the host. The host reaches both queues through one address on a simple register bus. A write to that address pushes a byte into the transmit queue. A read from it pops a byte from the receive queue. Back-to-back accesses to the address work as a burst, so a packet can be streamed without any change of address.

Three programmable 6-bit byte-count thresholds watch the queue levels. On the transmit side, one event fires when filling brings the level up to or past its threshold, and another fires when draining brings the level below its threshold. On the receive side, one event fires when filling brings the level up to or past its threshold. Each event fires once per crossing and sets a sticky status bit. Writing a one to a status bit clears it. The interrupt line is high while any status bit is set. Overflow and underflow of the host-side accesses are also recorded as status bits. Each queue also has a clear input that empties it at once.

Top module: `fifo_pair_ctl`

## Requirements
- R1: After reset both levels are 0, the status register (address 20h) reads 00h, `irq` is low, and the thresholds read 48 (transmit fill, 10h), 16 (transmit drain, 11h) and 48 (receive fill, 12h).
- R2: A bus write to address 7Fh pushes the byte into the transmit queue. Each `tx_pop` on a non-empty queue returns the bytes in write order on `tx_pop_data`, with `tx_pop_valid` high, in the cycle after the pop.
- R3: A bus write to 7Fh while the transmit queue holds 64 bytes is dropped. The level stays at 64 and status bit 3 (transmit overflow) is set.
- R4: Bytes pushed with `rx_push` come back in order from bus reads of 7Fh. `bus_rdata` is valid, with `bus_rvalid` high, in the cycle after the read.
- R5: A bus read of 7Fh while the receive queue is empty returns 00h and sets status bit 4 (receive underflow).
- R6: Status bit 0 is set when the transmit level rises from below the fill threshold to a value at or above it. It is set only once per crossing, so further pushes do not set it again after it has been cleared.
- R7: Status bit 1 is set when the transmit level falls from a value at or above the drain threshold to a value below it.
- R8: Status bit 2 is set when the receive level rises from below the receive fill threshold to a value at or above it.
- R9: A write to address 20h clears every status bit that is written as 1 and leaves the other bits as they are. `irq` is high exactly while any status bit is set.
- R10: A one-cycle pulse on `tx_clr` or `rx_clr` sets that queue's level to 0 without setting any status bit.
- R11: Thresholds are 6 bits wide. A write of FFh to a threshold address reads back as 3Fh.
- R12: `rx_push` while the receive queue holds 64 bytes is dropped. The level stays at 64 and the stored bytes are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read data valid |
| tx_pop | input | 1 | Modem pops a transmit byte |
| tx_pop_data | output | 8 | Popped transmit byte |
| tx_pop_valid | output | 1 | Popped byte valid |
| tx_level | output | 7 | Transmit queue level, 0 to 64 |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_push | input | 1 | Modem pushes a receive byte |
| rx_push_data | input | 8 | Received byte |
| rx_level | output | 7 | Receive queue level, 0 to 64 |
| rx_clr | input | 1 | Empty the receive queue |
| irq | output | 1 | High while any status bit is set |

## Verification
The hardest condition to reach from the ports is a crossing event that must fire exactly once. This needs the level stepped one byte at a time across a threshold, the sticky bit cleared, and the level then pushed further past the threshold to show that the bit stays clear. Directed sequences first program small thresholds so that crossings happen within a few bytes. They then fill each queue to its 64-byte limit to provoke the overflow and drop behaviour, and flush a queue that sits above its drain threshold to show that a clear raises no event. A seeded random mix of pushes, pops, reads and writes on both queues is checked against bench queue models for data order and level.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int BUS_AW = 7;
  localparam logic [BUS_AW-1:0] ADDR_FIFO    = 7'h7F;
  localparam logic [BUS_AW-1:0] ADDR_TX_FULL = 7'h10;
  localparam logic [BUS_AW-1:0] ADDR_TX_EMPT = 7'h11;
  localparam logic [BUS_AW-1:0] ADDR_RX_FULL = 7'h12;
  localparam logic [BUS_AW-1:0] ADDR_STATUS  = 7'h20;

  localparam int ST_TX_AF  = 0;
  localparam int ST_TX_AE  = 1;
  localparam int ST_RX_AF  = 2;
  localparam int ST_TX_OVF = 3;
  localparam int ST_RX_UDF = 4;
  localparam int ST_W      = 5;

  typedef enum logic [1:0] {SRC_REG, SRC_FIFO} rd_src_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DW = 8,
  parameter int AW = 6,
  localparam int LW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [LW-1:0] wr_ptr, rd_ptr;
  logic push_ok, pop_ok;

  assign level   = wr_ptr - rd_ptr;
  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = wr_en && !full && !clr;
  assign pop_ok  = rd_en && !empty && !clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) rd_data <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !clr) |=> full);
  p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en && !clr) |=> empty);
endmodule

// File: rtl/level_watch.sv
module level_watch #(
  parameter int LW = 7,
  parameter int TW = 6,
  parameter bit RISING = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [LW-1:0] level,
  input  logic [TW-1:0] thr,
  output logic          hit
);
  logic [LW-1:0] level_q;
  logic [LW-1:0] thr_x;

  assign thr_x = LW'(thr);

  always_ff @(posedge clk) begin
    if (rst || clr) level_q <= '0;
    else            level_q <= level;
  end

  generate
    if (RISING) begin : g_rise
      assign hit = !clr && (level > level_q) && (level >= thr_x) && (level_q < thr_x);
    end else begin : g_fall
      assign hit = !clr && (level < level_q) && (level < thr_x) && (level_q >= thr_x);
    end
  endgenerate

  p_hit_once_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/fifo_pair_ctl.sv
module fifo_pair_ctl
  import fifo_pair_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int TW = 6,
  parameter logic [TW-1:0] TX_FULL_RST = 6'd48,
  parameter logic [TW-1:0] TX_EMPT_RST = 6'd16,
  parameter logic [TW-1:0] RX_FULL_RST = 6'd48,
  localparam int LW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_pop_data,
  output logic              tx_pop_valid,
  output logic [LW-1:0]     tx_level,
  input  logic              tx_clr,
  input  logic              rx_push,
  input  logic [DW-1:0]     rx_push_data,
  output logic [LW-1:0]     rx_level,
  input  logic              rx_clr,
  output logic              irq
);
  logic wr_acc, rd_acc;
  logic tx_push_req, rx_pop_req;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_rd_data;
  logic [TW-1:0] thr_tx_full, thr_tx_empt, thr_rx_full;
  logic hit_tx_af, hit_tx_ae, hit_rx_af;
  logic [ST_W-1:0] status_q, st_set, st_clr;
  logic [DW-1:0] rdata_q;
  rd_src_e src_q;
  logic udf_q, rvalid_q, txv_q;

  assign wr_acc      = bus_sel && bus_wr;
  assign rd_acc      = bus_sel && !bus_wr;
  assign tx_push_req = wr_acc && (bus_addr == ADDR_FIFO);
  assign rx_pop_req  = rd_acc && (bus_addr == ADDR_FIFO);

  byte_fifo #(.DW(DW), .AW(AW)) u_tx_fifo (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .wr_en(tx_push_req), .wr_data(bus_wdata),
    .rd_en(tx_pop), .rd_data(tx_pop_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  byte_fifo #(.DW(DW), .AW(AW)) u_rx_fifo (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .wr_en(rx_push), .wr_data(rx_push_data),
    .rd_en(rx_pop_req), .rd_data(rx_rd_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  level_watch #(.LW(LW), .TW(TW), .RISING(1'b1)) u_tx_af (
    .clk(clk), .rst(rst), .clr(tx_clr), .level(tx_level), .thr(thr_tx_full), .hit(hit_tx_af));
  level_watch #(.LW(LW), .TW(TW), .RISING(1'b0)) u_tx_ae (
    .clk(clk), .rst(rst), .clr(tx_clr), .level(tx_level), .thr(thr_tx_empt), .hit(hit_tx_ae));
  level_watch #(.LW(LW), .TW(TW), .RISING(1'b1)) u_rx_af (
    .clk(clk), .rst(rst), .clr(rx_clr), .level(rx_level), .thr(thr_rx_full), .hit(hit_rx_af));

  // threshold registers
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_tx_full <= TX_FULL_RST;
      thr_tx_empt <= TX_EMPT_RST;
      thr_rx_full <= RX_FULL_RST;
    end else if (wr_acc) begin
      case (bus_addr)
        ADDR_TX_FULL: thr_tx_full <= bus_wdata[TW-1:0];
        ADDR_TX_EMPT: thr_tx_empt <= bus_wdata[TW-1:0];
        ADDR_RX_FULL: thr_rx_full <= bus_wdata[TW-1:0];
        default: ;
      endcase
    end
  end

  // sticky status, set wins over clear
  always_comb begin
    st_set = '0;
    st_set[ST_TX_AF]  = hit_tx_af;
    st_set[ST_TX_AE]  = hit_tx_ae;
    st_set[ST_RX_AF]  = hit_rx_af;
    st_set[ST_TX_OVF] = tx_push_req && tx_full && !tx_clr;
    st_set[ST_RX_UDF] = rx_pop_req && rx_empty && !rx_clr;
    st_clr = (wr_acc && bus_addr == ADDR_STATUS) ? bus_wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~st_clr) | st_set;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |((status_q & ~st_clr) | st_set);
  end

  // read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      src_q    <= SRC_REG;
      udf_q    <= 1'b0;
      rvalid_q <= 1'b0;
      txv_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      txv_q    <= tx_pop && !tx_empty && !tx_clr;
      if (rd_acc) begin
        src_q <= (bus_addr == ADDR_FIFO) ? SRC_FIFO : SRC_REG;
        udf_q <= rx_empty || rx_clr;
        case (bus_addr)
          ADDR_TX_FULL: rdata_q <= DW'(thr_tx_full);
          ADDR_TX_EMPT: rdata_q <= DW'(thr_tx_empt);
          ADDR_RX_FULL: rdata_q <= DW'(thr_rx_full);
          ADDR_STATUS:  rdata_q <= DW'(status_q);
          default:      rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata    = (src_q == SRC_FIFO) ? (udf_q ? '0 : rx_rd_data) : rdata_q;
  assign bus_rvalid   = rvalid_q;
  assign tx_pop_valid = txv_q;

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_push_req && tx_full && !tx_clr) |=> status_q[ST_TX_OVF]);
  p_udf_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_pop_req && rx_empty && !rx_clr) |=> (status_q[ST_RX_UDF] && bus_rdata == '0));
  p_irq_status_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (status_q != '0));
  p_rvalid_r4: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> bus_rvalid);
endmodule

// File: tb/fifo_pair_ctl_tb.sv
module fifo_pair_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid;
  logic tx_pop = 0;
  logic [7:0] tx_pop_data;
  logic tx_pop_valid;
  logic [6:0] tx_level, rx_level;
  logic tx_clr = 0, rx_clr = 0, rx_push = 0;
  logic [7:0] rx_push_data = '0;
  logic irq;

  int checks = 0, fails = 0;
  logic [7:0] txq[$], rxq[$];

  fifo_pair_ctl u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_pop_valid(tx_pop_valid),
    .tx_level(tx_level), .tx_clr(tx_clr), .rx_push(rx_push), .rx_push_data(rx_push_data),
    .rx_level(rx_level), .rx_clr(rx_clr), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; v = bus_rvalid; bus_sel = 0;
  endtask

  task automatic do_pop(output logic [7:0] d, output logic v);
    @(negedge clk); tx_pop = 1;
    @(negedge clk); d = tx_pop_data; v = tx_pop_valid; tx_pop = 0;
  endtask

  task automatic do_push(input logic [7:0] d);
    @(negedge clk); rx_push = 1; rx_push_data = d;
    @(negedge clk); rx_push = 0;
  endtask

  function automatic bit exp_irq(input logic [7:0] st);
    return st[4:0] != 0;
  endfunction

  task automatic check_status(input logic [7:0] exp, input string req);
    logic [7:0] d; logic v;
    idle(1);
    bus_read(7'h20, d, v);
    check(d == exp, req, d, exp);
    check(irq == exp_irq(exp), {req, " irq"}, irq, exp_irq(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    idle(3);
    rst = 0;
    idle(1);

    // R1 reset state
    check(tx_level == 0 && rx_level == 0, "R1 levels", tx_level + rx_level, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check_status(8'h00, "R1 status");
    bus_read(7'h10, d, v); check(d == 48, "R1 thr tx fill", d, 48);
    bus_read(7'h11, d, v); check(d == 16, "R1 thr tx drain", d, 16);
    bus_read(7'h12, d, v); check(d == 48, "R1 thr rx fill", d, 48);

    // R11 threshold width
    bus_write(7'h10, 8'hFF); bus_read(7'h10, d, v);
    check(d == 8'h3F, "R11 thr width", d, 8'h3F);

    // R6 fill crossing, R9 write-1-to-clear
    bus_write(7'h10, 8'd4);
    bus_write(7'h11, 8'd3);
    for (int i = 0; i < 3; i++) bus_write(7'h7F, 8'(8'h10 + i));
    check_status(8'h00, "R6 below thr");
    bus_write(7'h7F, 8'h13);
    check_status(8'h01, "R6 crossing");
    bus_write(7'h20, 8'h00);
    check_status(8'h01, "R9 zero write keeps");
    bus_write(7'h20, 8'h01);
    check_status(8'h00, "R9 clear");
    bus_write(7'h7F, 8'h14);
    check_status(8'h00, "R6 once per crossing");
    check(tx_level == 5, "R2 level", tx_level, 5);

    // R2 order, R7 drain crossing
    for (int i = 0; i < 2; i++) begin
      do_pop(d, v);
      check(v && d == 8'(8'h10 + i), "R2 pop order", d, 8'h10 + i);
    end
    check_status(8'h00, "R7 at thr");
    do_pop(d, v);
    check(d == 8'h12, "R2 pop order", d, 8'h12);
    check_status(8'h02, "R7 crossing");
    bus_write(7'h20, 8'hFF);

    // R10 flush above drain threshold raises nothing
    bus_write(7'h7F, 8'hAA); bus_write(7'h7F, 8'hAB);
    check(tx_level == 4, "R10 pre level", tx_level, 4);
    bus_write(7'h20, 8'hFF);
    @(negedge clk); tx_clr = 1; @(negedge clk); tx_clr = 0;
    check(tx_level == 0, "R10 tx flush", tx_level, 0);
    check_status(8'h00, "R10 no event");

    // R3 overflow
    for (int i = 0; i < 65; i++) bus_write(7'h7F, 8'(i * 3));
    check(tx_level == 64, "R3 level", tx_level, 64);
    check_status(8'h09, "R3 overflow");
    for (int i = 0; i < 64; i++) begin
      do_pop(d, v);
      check(d == 8'(i * 3), "R3 data kept", d, 8'(i * 3));
    end
    do_pop(d, v);
    check(v == 0, "R2 pop empty invalid", v, 0);
    bus_write(7'h20, 8'hFF);

    // R5 underflow
    bus_read(7'h7F, d, v);
    check(v && d == 8'h00, "R5 empty read", d, 0);
    check_status(8'h10, "R5 flag");
    bus_write(7'h20, 8'hFF);

    // R8 and R4
    bus_write(7'h12, 8'd2);
    do_push(8'h51);
    check_status(8'h00, "R8 below thr");
    do_push(8'h52);
    check_status(8'h04, "R8 crossing");
    bus_read(7'h7F, d, v); check(v && d == 8'h51, "R4 order", d, 8'h51);
    bus_read(7'h7F, d, v); check(d == 8'h52, "R4 order", d, 8'h52);
    bus_write(7'h20, 8'hFF);

    // R12 receive full drop
    for (int i = 0; i < 65; i++) do_push(8'(8'hC0 ^ i));
    check(rx_level == 64, "R12 level", rx_level, 64);
    for (int i = 0; i < 64; i++) begin
      bus_read(7'h7F, d, v);
      check(d == 8'(8'hC0 ^ i), "R12 data", d, 8'(8'hC0 ^ i));
    end
    check(rx_level == 0, "R12 drained", rx_level, 0);
    @(negedge clk); rx_clr = 1; @(negedge clk); rx_clr = 0;
    check(rx_level == 0, "R10 rx flush", rx_level, 0);

    // random mix against queue models: R2 R4
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      case ($urandom % 4)
        0: begin
          bus_write(7'h7F, b);
          if (txq.size() < 64) txq.push_back(b);
        end
        1: begin
          do_pop(d, v);
          if (txq.size() > 0) begin
            logic [7:0] e; e = txq.pop_front();
            check(v && d == e, "R2 random pop", d, e);
          end else check(v == 0, "R2 random empty", v, 0);
        end
        2: begin
          do_push(b);
          if (rxq.size() < 64) rxq.push_back(b);
        end
        default: begin
          logic [7:0] e;
          bus_read(7'h7F, d, v);
          e = (rxq.size() > 0) ? rxq.pop_front() : 8'h00;
          check(v && d == e, "R4 random read", d, e);
        end
      endcase
      check(tx_level == 7'(txq.size()), "R2 random tx level", tx_level, txq.size());
      check(rx_level == 7'(rxq.size()), "R4 random rx level", rx_level, rxq.size());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule